// File: doc/BRIEF.md
# Socket Event Status and Interrupt Register

This block is the event status register of a removable-card socket. It watches six raw socket lines: two card-detect pins, the card ready line, the battery-warning line, the battery-dead or status-change line and a ring-indicate line. It folds them into four sticky status bits and raises a level interrupt toward the host while any bit that is both enabled and allowed is set. Every raw line passes through a synchronizer before any edge or level is evaluated.

The host reads the register and then acknowledges the events it has handled. A global mode input selects how it does that. With `clr_mode_i` low, a read clears exactly the bits it returned. With `clr_mode_i` high, reads have no side effect and the host writes ones to the bits it wants cleared. Per-source enables, the installed card type and a ring-indicate selection decide which events are visible. A power-management enable decides whether the platform reset can wipe the latched bits, or whether only the global reset can.

Top module: `sock_evt_irq`

## Requirements
- R1: After the asynchronous global reset `rst_ni`, the register reads 00h and `irq_o` is low. Bits 7 to 4 always read 0.
- R2: Bit 3 sets on any edge, rising or falling, of either card-detect input. The bit is visible three clock edges after the input changes (two synchronizer flops, then the latch).
- R3: Bit 2 sets only on a rising edge of `card_rdy_i`; a falling edge does not set it. While `io_card_i` is 1, bit 2 reads 0 and cannot be set.
- R4: Bit 1 sets while `bat_warn_i` is high. While `io_card_i` is 1, bit 1 reads 0 and cannot be set.
- R5: With `ring_sel_i` at 0, bit 0 sets while `bat_dead_i` is high, for either card type. With `ring_sel_i` at 1, bit 0 sets while `ring_ind_i` is high, and `bat_dead_i` is ignored.
- R6: `src_en_i[k]` enables status bit k. A disabled source always reads 0 and latches nothing.
- R7: With `clr_mode_i` at 0, a cycle with `rd_i` high returns the value before the clear on `rd_data_o`, then clears the bits it returned at the next edge. Writes have no effect.
- R8: With `clr_mode_i` at 1, a cycle with `wr_i` high clears each status bit whose `wr_data_i` bit is 1. Bits written 0 keep their value, and reads have no side effect.
- R9: An event that reaches the latch in the same cycle as a clear of its bit, by read or by write, leaves the bit set.
- R10: `irq_o` is high exactly when any status bit reads 1. It falls in the cycle after the last set bit is cleared.
- R11: A cycle with `plat_rst_ni` low clears all status bits when `pme_en_i` is 0, and leaves them unchanged when `pme_en_i` is 1. The global reset clears them in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Global reset, asynchronous, active low |
| plat_rst_ni | input | 1 | Platform reset, synchronous, active low |
| pme_en_i | input | 1 | Power-management enable; when 1, status survives the platform reset |
| clr_mode_i | input | 1 | 0: clear on read, 1: write one to clear |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data; bits 3..0 select the bits to clear |
| rd_data_o | output | 8 | Current register value |
| det_a_i | input | 1 | First card-detect line, asynchronous |
| det_b_i | input | 1 | Second card-detect line, asynchronous |
| card_rdy_i | input | 1 | Card ready line, asynchronous |
| bat_warn_i | input | 1 | Battery-warning line, asynchronous |
| bat_dead_i | input | 1 | Battery-dead or status-change line, asynchronous |
| ring_ind_i | input | 1 | Ring-indicate line, asynchronous |
| ring_sel_i | input | 1 | Bit 0 follows ring indicate when 1 |
| io_card_i | input | 1 | An I/O-type card is installed |
| src_en_i | input | 4 | Per-bit source enables, bit k enables status bit k |
| irq_o | output | 1 | Host interrupt request, level |

## Verification
The assertions check the static masking rules on every cycle. Reserved bits stay zero, a disabled or card-type-masked bit never reads 1, and the interrupt matches the OR of the visible bits. They also check two rules over time: a platform reset with power management off empties the register by the next cycle, and in write-one-to-clear mode a cycle without a write never loses a bit. What the assertions cannot see, because it depends on the raw lines and their synchronizer latency, is covered by the bench scenarios. These are the edge-versus-level behaviour of each source, the read-returns-then-clears ordering, and an event arriving in the very cycle its bit is being cleared.

// File: rtl/sock_evt_pkg.sv
package sock_evt_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned NSRC  = 4;
  localparam int unsigned NRAW  = 6;

  // raw input positions in the synchronized vector
  localparam int unsigned RAW_DET_A = 0;
  localparam int unsigned RAW_DET_B = 1;
  localparam int unsigned RAW_RDY   = 2;
  localparam int unsigned RAW_WARN  = 3;
  localparam int unsigned RAW_DEAD  = 4;
  localparam int unsigned RAW_RING  = 5;

  // status bit positions (software-visible)
  localparam int unsigned ST_DEAD = 0;
  localparam int unsigned ST_WARN = 1;
  localparam int unsigned ST_RDY  = 2;
  localparam int unsigned ST_DET  = 3;

  typedef logic [NSRC-1:0] src_vec_t;
  typedef logic [NRAW-1:0] raw_vec_t;
endpackage

// File: rtl/sock_sync.sv
module sock_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sock_evt_detect.sv
module sock_evt_detect
  import sock_evt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  raw_vec_t raw_i,
  input  logic     ring_sel_i,
  input  logic     io_card_i,
  output src_vec_t evt_o,
  output src_vec_t card_mask_o
);
  // previous value only for the edge-detected lines
  logic det_a_q, det_b_q, rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_a_q <= 1'b0;
      det_b_q <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      det_a_q <= raw_i[RAW_DET_A];
      det_b_q <= raw_i[RAW_DET_B];
      rdy_q   <= raw_i[RAW_RDY];
    end
  end

  always_comb begin
    evt_o          = '0;
    evt_o[ST_DET]  = (raw_i[RAW_DET_A] ^ det_a_q) | (raw_i[RAW_DET_B] ^ det_b_q);
    evt_o[ST_RDY]  = raw_i[RAW_RDY] & ~rdy_q;
    evt_o[ST_WARN] = raw_i[RAW_WARN];
    evt_o[ST_DEAD] = ring_sel_i ? raw_i[RAW_RING] : raw_i[RAW_DEAD];
  end

  always_comb begin
    card_mask_o          = '1;
    card_mask_o[ST_RDY]  = ~io_card_i;
    card_mask_o[ST_WARN] = ~io_card_i;
  end
endmodule

// File: rtl/sock_evt_latch.sv
module sock_evt_latch #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            plat_rst_ni,
  input  logic            pme_en_i,
  input  logic            clr_mode_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [NSRC-1:0] wr_bits_i,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] keep_i,
  output logic [NSRC-1:0] vis_o
);
  logic [NSRC-1:0] clr;
  logic            plat_clr;

  assign plat_clr = ~plat_rst_ni & ~pme_en_i;
  // read clears only what it returned; write clears what software names
  assign clr = clr_mode_i ? (wr_i ? wr_bits_i : '0)
                          : (rd_i ? vis_o     : '0);

  for (genvar k = 0; k < NSRC; k++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bit_q <= 1'b0;
      end else if (plat_clr) begin
        bit_q <= 1'b0;
      end else begin
        // new event wins over a same-cycle clear; masked bits are dropped
        bit_q <= (bit_q & keep_i[k] & ~clr[k]) | (evt_i[k] & keep_i[k]);
      end
    end
    assign vis_o[k] = bit_q & keep_i[k];
  end
endmodule

// File: rtl/sock_evt_irq.sv
module sock_evt_irq
  import sock_evt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             plat_rst_ni,
  input  logic             pme_en_i,
  input  logic             clr_mode_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             det_a_i,
  input  logic             det_b_i,
  input  logic             card_rdy_i,
  input  logic             bat_warn_i,
  input  logic             bat_dead_i,
  input  logic             ring_ind_i,
  input  logic             ring_sel_i,
  input  logic             io_card_i,
  input  logic [NSRC-1:0]  src_en_i,
  output logic             irq_o
);
  localparam int unsigned RSVD_W = REG_W - NSRC;

  raw_vec_t raw_async, raw_sync;
  src_vec_t evt, card_mask, keep, vis;
  logic     unused_wr_hi;

  always_comb begin
    raw_async            = '0;
    raw_async[RAW_DET_A] = det_a_i;
    raw_async[RAW_DET_B] = det_b_i;
    raw_async[RAW_RDY]   = card_rdy_i;
    raw_async[RAW_WARN]  = bat_warn_i;
    raw_async[RAW_DEAD]  = bat_dead_i;
    raw_async[RAW_RING]  = ring_ind_i;
  end

  sock_sync #(.W(NRAW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_async),
    .q_o   (raw_sync)
  );

  sock_evt_detect u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .raw_i      (raw_sync),
    .ring_sel_i (ring_sel_i),
    .io_card_i  (io_card_i),
    .evt_o      (evt),
    .card_mask_o(card_mask)
  );

  assign keep = src_en_i & card_mask;

  sock_evt_latch #(.NSRC(NSRC)) u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .plat_rst_ni(plat_rst_ni),
    .pme_en_i   (pme_en_i),
    .clr_mode_i (clr_mode_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .wr_bits_i  (wr_data_i[NSRC-1:0]),
    .evt_i      (evt),
    .keep_i     (keep),
    .vis_o      (vis)
  );

  assign unused_wr_hi = ^wr_data_i[REG_W-1:NSRC];
  assign rd_data_o    = {{RSVD_W{1'b0}}, vis};
  assign irq_o        = |vis;
endmodule

// File: rtl/sock_evt_irq_chk.sv
module sock_evt_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       plat_rst_ni,
  input logic       pme_en_i,
  input logic       clr_mode_i,
  input logic       wr_i,
  input logic [7:0] rd_data_o,
  input logic       io_card_i,
  input logic [3:0] src_en_i,
  input logic       irq_o
);
  assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7:4] == 4'h0);

  assert_en_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[3:0] & ~src_en_i) == 4'h0);

  // covers R4 as well: bits 2 and 1 masked for I/O cards
  assert_io_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_card_i |-> rd_data_o[2:1] == 2'b00);

  assert_irq_any_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (rd_data_o[3:0] != 4'h0));

  assert_plat_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!plat_rst_ni && !pme_en_i) |=> rd_data_o[3:0] == 4'h0);

  assert_w1c_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_mode_i && !wr_i && plat_rst_ni) |=>
      ((src_en_i != $past(src_en_i)) || (io_card_i != $past(io_card_i)) ||
       ((rd_data_o[3:0] & $past(rd_data_o[3:0])) == $past(rd_data_o[3:0]))));
endmodule

bind sock_evt_irq sock_evt_irq_chk u_chk (.*);

// File: tb/sock_evt_irq_tb.sv
`timescale 1ns/1ps
module sock_evt_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n, plat_rst_n, pme_en, clr_mode, rd, wr;
  logic [7:0] wdata, rdata;
  logic       det_a, det_b, rdy, warn, dead, ring, ring_sel, io_card, irq;
  logic [3:0] en;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sock_evt_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .plat_rst_ni(plat_rst_n), .pme_en_i(pme_en),
    .clr_mode_i(clr_mode), .rd_i(rd), .wr_i(wr), .wr_data_i(wdata),
    .rd_data_o(rdata), .det_a_i(det_a), .det_b_i(det_b), .card_rdy_i(rdy),
    .bat_warn_i(warn), .bat_dead_i(dead), .ring_ind_i(ring),
    .ring_sel_i(ring_sel), .io_card_i(io_card), .src_en_i(en), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // raise one source, hold it, release it, let the synchronizer settle
  task automatic fire(input int src);
    case (src)
      3: det_a = ~det_a;
      2: rdy = 1'b1;
      1: warn = 1'b1;
      default: dead = 1'b1;
    endcase
    step(4);
    rdy = 1'b0; warn = 1'b0; dead = 1'b0;
    step(4);
  endtask

  task automatic w1c(input logic [7:0] bits);
    wr = 1'b1; wdata = bits; step(1); wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; plat_rst_n = 1'b1; pme_en = 1'b0; clr_mode = 1'b0;
    rd = 1'b0; wr = 1'b0; wdata = 8'h00;
    det_a = 1'b0; det_b = 1'b0; rdy = 1'b0; warn = 1'b0; dead = 1'b0; ring = 1'b0;
    ring_sel = 1'b0; io_card = 1'b0; en = 4'hF;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 reset value", rdata, 8'h00);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);

    // sweep: clear mode x source x enable
    for (int mode = 0; mode < 2; mode++) begin
      for (int src = 0; src < 4; src++) begin
        for (int on = 0; on < 2; on++) begin
          string tag;
          logic [7:0] exp;
          case (src)
            3: tag = "R2 detect edge";
            2: tag = "R3 ready rise";
            1: tag = "R4 battery warn";
            default: tag = "R5 battery dead";
          endcase
          clr_mode = mode[0];
          en = on[0] ? 4'hF : (4'hF & ~(4'b1 << src));
          step(1);
          fire(src);
          exp = on[0] ? (8'h01 << src) : 8'h00;
          chk(on[0] ? tag : "R6 disabled source", rdata, exp);
          chk("R10 irq level", {7'b0, irq}, {7'b0, on[0]});
          if (mode == 0) begin
            w1c(8'hFF);
            chk("R7 write ignored", rdata, exp);
            rd = 1'b1;
            chk("R7 pre-clear value", rdata, exp);
            step(1);
            rd = 1'b0;
            chk("R7 read cleared", rdata, 8'h00);
          end else begin
            rd = 1'b1; step(1); rd = 1'b0;
            chk("R8 read no side effect", rdata, exp);
            w1c(8'h00);
            chk("R8 zero write keeps", rdata, exp);
            w1c(exp);
            chk("R8 one write clears", rdata, 8'h00);
          end
          chk("R10 irq after clear", {7'b0, irq}, 8'h00);
        end
      end
    end

    en = 4'hF; clr_mode = 1'b1;
    // R10: irq holds until the last bit is gone
    fire(3); fire(1);
    chk("R10 two bits", rdata, 8'h0A);
    w1c(8'h08);
    chk("R10 irq with one left", {7'b0, irq}, 8'h01);
    wr = 1'b1; wdata = 8'h02;
    chk("R10 irq before last clear edge", {7'b0, irq}, 8'h01);
    step(1); wr = 1'b0; wdata = 8'h00;
    chk("R10 irq falls after last clear", {7'b0, irq}, 8'h00);

    // R2: second detect input, both edges
    det_b = 1'b1; step(4);
    chk("R2 det_b rise", rdata, 8'h08);
    w1c(8'h08);
    det_b = 1'b0; step(4);
    chk("R2 det_b fall", rdata, 8'h08);
    w1c(8'h08);

    // R3: falling ready edge does not set
    rdy = 1'b1; step(4);
    chk("R3 ready rise", rdata, 8'h04);
    w1c(8'h04);
    rdy = 1'b0; step(4);
    chk("R3 ready fall ignored", rdata, 8'h00);

    // R3/R4: I/O card masks ready and warning, not bit 0
    io_card = 1'b1; step(1);
    fire(2); fire(1);
    chk("R3 R4 io card masks", rdata, 8'h00);
    fire(0);
    chk("R5 io card bit0", rdata, 8'h01);
    w1c(8'h01);
    io_card = 1'b0;
    warn = 1'b1; step(4); warn = 1'b0; step(4);
    chk("R4 warn memory card", rdata, 8'h02);
    io_card = 1'b1; step(1);
    chk("R4 io card hides warn", rdata, 8'h00);
    io_card = 1'b0; step(1);

    // R5: ring-indicate selection
    ring_sel = 1'b1; step(1);
    fire(0);
    chk("R5 dead ignored in ring mode", rdata, 8'h00);
    ring = 1'b1; step(4); ring = 1'b0; step(4);
    chk("R5 ring sets bit0", rdata, 8'h01);
    w1c(8'h01);
    ring_sel = 1'b0; step(1);

    // R9: event in the same cycle as a clear (read mode)
    clr_mode = 1'b0;
    fire(3);
    chk("R9 setup", rdata, 8'h08);
    det_a = ~det_a; step(2);
    rd = 1'b1;
    chk("R9 read value", rdata, 8'h08);
    step(1); rd = 1'b0;
    chk("R9 event beats read clear", rdata, 8'h08);
    rd = 1'b1; step(1); rd = 1'b0;
    chk("R7 plain read clear", rdata, 8'h00);

    // R9: event in the same cycle as a clear (write mode)
    clr_mode = 1'b1;
    fire(3);
    det_a = ~det_a; step(2);
    w1c(8'h08);
    chk("R9 event beats write clear", rdata, 8'h08);
    w1c(8'h08);
    chk("R9 later clear", rdata, 8'h00);

    // R11: platform reset vs power management
    det_a = 1'b0; det_b = 1'b0; step(4);
    w1c(8'h0F);
    pme_en = 1'b1;
    fire(1);
    plat_rst_n = 1'b0; step(1); plat_rst_n = 1'b1;
    chk("R11 platform reset held off", rdata, 8'h02);
    pme_en = 1'b0;
    plat_rst_n = 1'b0; step(1); plat_rst_n = 1'b1;
    chk("R11 platform reset clears", rdata, 8'h00);
    pme_en = 1'b1;
    fire(1);
    rst_n = 1'b0; step(1); rst_n = 1'b1; step(1);
    chk("R11 global reset clears", rdata, 8'h00);
    chk("R1 irq after global reset", {7'b0, irq}, 8'h00);

    finish_run();
  end
endmodule